// File: doc/BRIEF.md
# Primary Data Cache Write-Policy Controller

This controller takes one memory access at a time (a load, an instruction fetch or a store) together with a 3-bit caching attribute, the primary hit status and the dirty bit of the addressed (or victim) line. From these it decides which memory actions the access needs and issues them as commands. Each command is held until the matching done handshake returns. The commands are: write back a dirty victim, fill a line into the primary, read memory directly, and write main memory. Each victim write-back and each fill also carries flags saying whether the secondary level may be looked up, filled or written.

The access finishes with a one-cycle completion pulse. In that same cycle the controller raises strobes that tell the primary to write the store data and, for the write-back attributes, to set the line's dirty bit. The data arrays, the bus protocol and the victim choice are outside this block. The fill and memory ports are plain request/done pairs.

Top module: `wpolicy_ctrl`

## Requirements
- R1: Attribute encoding is 0 uncached, 1 write-through with allocate, 2 write-through without allocate, 3 write-back, 4 write-back with secondary bypass. Codes 5 to 7 behave as uncached. An uncached load or fetch issues only a direct memory read (`memRdReq`). An uncached store issues only a memory write. No fill, victim write-back, primary update or secondary flag occurs for an uncached access.
- R2: Access type encoding is 0 load, 1 fetch, 2 store, and 3 behaves as a load. A cacheable load or fetch that hits the primary issues no command and simply completes.
- R3: A cacheable load or fetch that misses issues a fill. `fillSecLookup` and `fillSecFill` are high during that fill only for attribute 3. They stay low for attributes 1, 2 and 4.
- R4: Whenever a fill is needed and `lineDirty` is 1, a victim write-back is issued first. `victimSecWr` is high during it only for attribute 3.
- R5: With attribute 1, a store hit gives a primary update plus a memory write and never sets dirty. A store miss first fills the line and then does the same.
- R6: With attribute 2, a store hit gives a primary update plus a memory write. A store miss gives only a memory write, with no fill, no victim write-back and no primary update.
- R7: With attributes 3 and 4, a store hit gives a primary update with dirty set and no memory write. A store miss fills the line first and then updates it and sets dirty.
- R8: Each command stays high until its done input is seen. Only one command is high at a time. `reqReady` is low from acceptance until the completion pulse, and requests offered while busy are ignored.
- R9: After reset `reqReady` is 1 and every command and strobe is 0.
- R10: Commands come in the order victim write-back, fill, memory read, memory write. `priUpdate` and `setDirty` appear only in the cycle of `accDone`, after all commands have completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access offered |
| reqType | input | 2 | Access type (R2) |
| reqAttr | input | 3 | Caching attribute (R1) |
| primHit | input | 1 | Primary hit for the access |
| lineDirty | input | 1 | Dirty bit of the line to be replaced |
| reqReady | output | 1 | Controller idle, access accepted when valid |
| victimReq | output | 1 | Write back dirty victim line |
| victimSecWr | output | 1 | Victim write-back may write the secondary |
| victimDone | input | 1 | Victim write-back complete |
| fillReq | output | 1 | Fill line into primary |
| fillSecLookup | output | 1 | Fill may look up the secondary |
| fillSecFill | output | 1 | Fill may allocate in the secondary |
| fillDone | input | 1 | Fill complete |
| memRdReq | output | 1 | Direct uncached memory read |
| memRdDone | input | 1 | Memory read complete |
| memWrReq | output | 1 | Main memory write |
| memWrDone | input | 1 | Memory write complete |
| priUpdate | output | 1 | Write store data into primary line |
| setDirty | output | 1 | Mark primary line dirty |
| accDone | output | 1 | Access complete pulse |

## Verification
A table of accesses walks every attribute, including the unused codes, with loads, fetches, stores and the reserved type. Each attribute is tried with hit, clean miss and dirty miss. The hit/miss pairs separate the allocate and no-allocate write-through modes. The clean/dirty pairs check that a victim write-back appears only when a fill happens. Attributes 3 and 4 under the same miss show the secondary flags being cut off by the bypass mode. A directed run withholds a done handshake and offers a second request to show the hold and busy behaviour.

// File: rtl/wpolicy_pkg.sv
package wpolicy_pkg;
  localparam int TYPE_W = 2;
  localparam int ATTR_W = 3;

  localparam logic [ATTR_W-1:0] ATTR_UNC  = 3'd0;
  localparam logic [ATTR_W-1:0] ATTR_WTA  = 3'd1;
  localparam logic [ATTR_W-1:0] ATTR_WTN  = 3'd2;
  localparam logic [ATTR_W-1:0] ATTR_WB   = 3'd3;
  localparam logic [ATTR_W-1:0] ATTR_WBNS = 3'd4;
  localparam logic [TYPE_W-1:0] TYPE_ST   = 2'd2;

  typedef enum logic [2:0] {
    STEP_IDLE   = 3'd0,
    STEP_VICTIM = 3'd1,
    STEP_FILL   = 3'd2,
    STEP_MEMRD  = 3'd3,
    STEP_MEMWR  = 3'd4,
    STEP_FINISH = 3'd5
  } stepT;

  typedef struct packed {
    logic victim;
    logic victimSec;
    logic fill;
    logic secLookup;
    logic secFill;
    logic memRd;
    logic memWr;
    logic priUpd;
    logic setDirty;
  } planT;

  typedef struct packed {
    logic capture;
    logic inVictim;
    logic inFill;
    logic finish;
  } ctlT;

  function automatic planT planFor(logic [TYPE_W-1:0] t, logic [ATTR_W-1:0] a,
                                   logic hit, logic dirty);
    planT p;
    logic isStore, cacheable, wbMode, secOk;
    p = '0;
    isStore   = (t == TYPE_ST);
    cacheable = (a >= ATTR_WTA) && (a <= ATTR_WBNS);
    wbMode    = (a == ATTR_WB) || (a == ATTR_WBNS);
    secOk     = (a == ATTR_WB);
    if (!cacheable) begin
      p.memRd = !isStore;
      p.memWr = isStore;
    end else if (!isStore) begin
      p.fill = !hit;
    end else begin
      p.fill     = !hit && (a != ATTR_WTN);
      p.memWr    = !wbMode;
      p.priUpd   = hit || p.fill;
      p.setDirty = wbMode;
    end
    p.victim    = p.fill && dirty;
    p.victimSec = p.victim && secOk;
    p.secLookup = p.fill && secOk;
    p.secFill   = p.fill && secOk;
    return p;
  endfunction

  function automatic stepT stepAfter(planT p, stepT from);
    if (from < STEP_VICTIM && p.victim) return STEP_VICTIM;
    if (from < STEP_FILL   && p.fill)   return STEP_FILL;
    if (from < STEP_MEMRD  && p.memRd)  return STEP_MEMRD;
    if (from < STEP_MEMWR  && p.memWr)  return STEP_MEMWR;
    return STEP_FINISH;
  endfunction
endpackage

// File: rtl/wpolicy_plan.sv
module wpolicy_plan
  import wpolicy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlT               ctl,
  input  logic [TYPE_W-1:0] reqType,
  input  logic [ATTR_W-1:0] reqAttr,
  input  logic              primHit,
  input  logic              lineDirty,
  output planT              planNext,
  output planT              planCur,
  output logic              victimSecWr,
  output logic              fillSecLookup,
  output logic              fillSecFill,
  output logic              priUpdate,
  output logic              setDirty
);
  logic [ATTR_W-1:0] capAttr;

  assign planNext = planFor(reqType, reqAttr, primHit, lineDirty);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      planCur <= '0;
      capAttr <= ATTR_UNC;
    end else if (ctl.capture) begin
      planCur <= planNext;
      capAttr <= reqAttr;
    end
  end

  assign victimSecWr   = ctl.inVictim & planCur.victimSec;
  assign fillSecLookup = ctl.inFill & planCur.secLookup;
  assign fillSecFill   = ctl.inFill & planCur.secFill;
  assign priUpdate     = ctl.finish & planCur.priUpd;
  assign setDirty      = ctl.finish & planCur.setDirty;

  assert_dirty_wb_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    setDirty |-> (capAttr == ATTR_WB || capAttr == ATTR_WBNS));
  assert_sec_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    victimSecWr |-> capAttr == ATTR_WB);
  assert_sec_fill_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fillSecLookup || fillSecFill) |-> capAttr == ATTR_WB);
  assert_no_update_uncached_R1: assert property (@(posedge clk) disable iff (!rstN)
    priUpdate |-> (capAttr >= ATTR_WTA && capAttr <= ATTR_WBNS));
endmodule

// File: rtl/wpolicy_seq.sv
module wpolicy_seq
  import wpolicy_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  planT planNext,
  input  planT planCur,
  input  logic victimDone,
  input  logic fillDone,
  input  logic memRdDone,
  input  logic memWrDone,
  output ctlT  ctl,
  output logic reqReady,
  output logic victimReq,
  output logic fillReq,
  output logic memRdReq,
  output logic memWrReq,
  output logic accDone
);
  stepT step, stepNxt;

  always_comb begin
    stepNxt = step;
    unique case (step)
      STEP_IDLE:   if (reqValid) stepNxt = stepAfter(planNext, STEP_IDLE);
      STEP_VICTIM: if (victimDone) stepNxt = stepAfter(planCur, STEP_VICTIM);
      STEP_FILL:   if (fillDone) stepNxt = stepAfter(planCur, STEP_FILL);
      STEP_MEMRD:  if (memRdDone) stepNxt = stepAfter(planCur, STEP_MEMRD);
      STEP_MEMWR:  if (memWrDone) stepNxt = stepAfter(planCur, STEP_MEMWR);
      STEP_FINISH: stepNxt = STEP_IDLE;
      default:     stepNxt = STEP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) step <= STEP_IDLE;
    else       step <= stepNxt;
  end

  assign reqReady  = (step == STEP_IDLE);
  assign victimReq = (step == STEP_VICTIM);
  assign fillReq   = (step == STEP_FILL);
  assign memRdReq  = (step == STEP_MEMRD);
  assign memWrReq  = (step == STEP_MEMWR);
  assign accDone   = (step == STEP_FINISH);

  assign ctl.capture  = reqReady & reqValid;
  assign ctl.inVictim = victimReq;
  assign ctl.inFill   = fillReq;
  assign ctl.finish   = accDone;

  assert_one_cmd_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({victimReq, fillReq, memRdReq, memWrReq, accDone}));
  assert_hold_victim_R8: assert property (@(posedge clk) disable iff (!rstN)
    victimReq && !victimDone |=> victimReq);
  assert_hold_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    fillReq && !fillDone |=> fillReq);
  assert_hold_memrd_R8: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && !memRdDone |=> memRdReq);
  assert_hold_memwr_R8: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq && !memWrDone |=> memWrReq);
  assert_ready_after_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    accDone |=> reqReady);
  assert_victim_before_fill_R10: assert property (@(posedge clk) disable iff (!rstN)
    victimReq && victimDone && planCur.fill |=> fillReq);
endmodule

// File: rtl/wpolicy_ctrl.sv
module wpolicy_ctrl
  import wpolicy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [TYPE_W-1:0] reqType,
  input  logic [ATTR_W-1:0] reqAttr,
  input  logic              primHit,
  input  logic              lineDirty,
  output logic              reqReady,
  output logic              victimReq,
  output logic              victimSecWr,
  input  logic              victimDone,
  output logic              fillReq,
  output logic              fillSecLookup,
  output logic              fillSecFill,
  input  logic              fillDone,
  output logic              memRdReq,
  input  logic              memRdDone,
  output logic              memWrReq,
  input  logic              memWrDone,
  output logic              priUpdate,
  output logic              setDirty,
  output logic              accDone
);
  ctlT  ctl;
  planT planNext, planCur;

  wpolicy_plan u_plan (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqType(reqType), .reqAttr(reqAttr), .primHit(primHit), .lineDirty(lineDirty),
    .planNext(planNext), .planCur(planCur),
    .victimSecWr(victimSecWr), .fillSecLookup(fillSecLookup), .fillSecFill(fillSecFill),
    .priUpdate(priUpdate), .setDirty(setDirty)
  );

  wpolicy_seq u_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .planNext(planNext), .planCur(planCur),
    .victimDone(victimDone), .fillDone(fillDone),
    .memRdDone(memRdDone), .memWrDone(memWrDone),
    .ctl(ctl), .reqReady(reqReady), .victimReq(victimReq), .fillReq(fillReq),
    .memRdReq(memRdReq), .memWrReq(memWrReq), .accDone(accDone)
  );
endmodule

// File: tb/sim_wpolicy_ctrl.sv
module sim_wpolicy_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqType = '0;
  logic [2:0] reqAttr = '0;
  logic primHit = 1'b0, lineDirty = 1'b0;
  logic victimDone = 1'b0, fillDone = 1'b0, memRdDone = 1'b0, memWrDone = 1'b0;
  logic reqReady, victimReq, victimSecWr, fillReq, fillSecLookup, fillSecFill;
  logic memRdReq, memWrReq, priUpdate, setDirty, accDone;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  wpolicy_ctrl u0 (.*);

  // {type[1:0], attr[2:0], hit, dirty, expected[8:0]}
  // expected: victim, victimSec, fill, fillLookup, fillSecFill, memRd, memWr, priUpd, setDirty
  localparam int NV = 22;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 3'd0, 1'b0, 1'b0, 9'b000001000},  // R1 uncached load
    {2'd1, 3'd7, 1'b1, 1'b1, 9'b000001000},  // R1 unused code fetch
    {2'd2, 3'd0, 1'b0, 1'b1, 9'b000000100},  // R1 uncached store
    {2'd2, 3'd5, 1'b1, 1'b0, 9'b000000100},  // R1 unused code store
    {2'd0, 3'd1, 1'b1, 1'b0, 9'b000000000},  // R2 load hit
    {2'd1, 3'd3, 1'b1, 1'b1, 9'b000000000},  // R2 fetch hit
    {2'd0, 3'd3, 1'b0, 1'b0, 9'b001110000},  // R3 wb load miss
    {2'd0, 3'd4, 1'b0, 1'b0, 9'b001000000},  // R3 bypass load miss
    {2'd0, 3'd1, 1'b0, 1'b1, 9'b101000000},  // R4 wt dirty victim
    {2'd1, 3'd3, 1'b0, 1'b1, 9'b111110000},  // R4 wb dirty victim
    {2'd0, 3'd4, 1'b0, 1'b1, 9'b101000000},  // R4 bypass dirty victim
    {2'd0, 3'd2, 1'b0, 1'b0, 9'b001000000},  // R3 wt-noalloc load miss
    {2'd2, 3'd1, 1'b1, 1'b0, 9'b000000110},  // R5 store hit
    {2'd2, 3'd1, 1'b0, 1'b0, 9'b001000110},  // R5 store miss
    {2'd2, 3'd2, 1'b1, 1'b0, 9'b000000110},  // R6 store hit
    {2'd2, 3'd2, 1'b0, 1'b1, 9'b000000100},  // R6 store miss
    {2'd2, 3'd3, 1'b1, 1'b0, 9'b000000011},  // R7 wb store hit
    {2'd2, 3'd3, 1'b0, 1'b0, 9'b001110011},  // R7 wb store miss
    {2'd2, 3'd4, 1'b1, 1'b1, 9'b000000011},  // R7 bypass store hit
    {2'd2, 3'd4, 1'b0, 1'b1, 9'b101000011},  // R7 bypass store dirty miss
    {2'd2, 3'd3, 1'b0, 1'b1, 9'b111110011},  // R7 wb store dirty miss
    {2'd3, 3'd3, 1'b0, 1'b0, 9'b001110000}   // R2 reserved type as load
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one access; answers each command with done after holdCycles.
  task automatic runAccess(input logic [1:0] t, input logic [2:0] a, input logic h,
                           input logic d, input int holdCycles,
                           output logic [8:0] obs, output bit orderOk, output bit busyOk);
    int lastStep = 0;
    int waitCnt = 0;
    obs = '0; orderOk = 1'b1; busyOk = 1'b1;
    @(negedge clk);
    reqValid = 1'b1; reqType = t; reqAttr = a; primHit = h; lineDirty = d;
    @(negedge clk);
    reqValid = 1'b0;
    for (int cyc = 0; cyc < 100; cyc++) begin
      int stepNow;
      victimDone = 1'b0; fillDone = 1'b0; memRdDone = 1'b0; memWrDone = 1'b0;
      stepNow = victimReq ? 1 : fillReq ? 2 : memRdReq ? 3 : memWrReq ? 4 : accDone ? 5 : 0;
      if (reqReady) busyOk = 1'b0;
      if (victimReq) begin obs[8] = 1'b1; obs[7] = obs[7] | victimSecWr; end
      if (fillReq) begin obs[6] = 1'b1; obs[5] = obs[5] | fillSecLookup; obs[4] = obs[4] | fillSecFill; end
      if (memRdReq) obs[3] = 1'b1;
      if (memWrReq) obs[2] = 1'b1;
      if (priUpdate) obs[1] = 1'b1;
      if (setDirty) obs[0] = 1'b1;
      if ((priUpdate || setDirty) && !accDone) orderOk = 1'b0;
      if (stepNow != 0 && stepNow < lastStep) orderOk = 1'b0;
      if (stepNow != lastStep) waitCnt = 0;
      if (stepNow != 0) lastStep = stepNow;
      if (accDone) begin
        @(negedge clk);
        return;
      end
      if (stepNow >= 1 && stepNow <= 4) begin
        if (waitCnt >= holdCycles) begin
          victimDone = victimReq; fillDone = fillReq;
          memRdDone = memRdReq; memWrDone = memWrReq;
        end
        waitCnt++;
      end
      @(negedge clk);
    end
    orderOk = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [8:0] obs;
    bit orderOk, busyOk;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(reqReady === 1'b1, "R9 ready", int'(reqReady), 1);
    check({victimReq, fillReq, memRdReq, memWrReq, priUpdate, setDirty, accDone,
           victimSecWr, fillSecLookup, fillSecFill} === '0, "R9 outputs idle",
          int'({victimReq, fillReq, memRdReq, memWrReq, priUpdate, setDirty, accDone}), 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      runAccess(v[15:14], v[13:11], v[10], v[9], i % 3, obs, orderOk, busyOk);
      if (obs !== v[8:0])
        $display("FAIL vector %0d R1-R7 table actual=%b expected=%b", i, obs, v[8:0]);
      checks++;
      if (obs !== v[8:0]) failures++;
      check(orderOk, "R10 order", int'(orderOk), 1);
    end

    // R8: withhold memory-write done, offer a second request while busy
    begin
      bit held = 1'b1;
      bit noAccept = 1'b1;
      @(negedge clk);
      reqValid = 1'b1; reqType = 2'd2; reqAttr = 3'd2; primHit = 1'b0; lineDirty = 1'b0;
      @(negedge clk);
      reqType = 2'd0; reqAttr = 3'd0;  // second request offered while busy
      for (int k = 0; k < 6; k++) begin
        if (!memWrReq) held = 1'b0;
        if (reqReady) noAccept = 1'b0;
        @(negedge clk);
      end
      check(held, "R8 memWrReq held without done", int'(held), 1);
      check(noAccept, "R8 reqReady low while busy", int'(noAccept), 1);
      reqValid = 1'b0;
      memWrDone = 1'b1;
      @(negedge clk);
      memWrDone = 1'b0;
      check(accDone === 1'b1, "R8 done after handshake", int'(accDone), 1);
      @(negedge clk);
      @(negedge clk);
      check({reqReady, memRdReq, memWrReq} === 3'b100, "R8 busy request ignored",
            int'({reqReady, memRdReq, memWrReq}), 4);
    end

    // R4 long victim hold: victimSecWr stays with victimReq
    runAccess(2'd0, 3'd3, 1'b0, 1'b1, 5, obs, orderOk, busyOk);
    check(obs === 9'b111110000, "R4 slow victim", int'(obs), 'h1F0);
    check(busyOk, "R8 busy across slow victim", int'(busyOk), 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule